// File: doc/BRIEF.md
# Serial Configuration Register Bank with Write Key

This block is a three-wire serial slave, with a serial clock, a data-in line and a data-out line, placed in front of a small bank of 8-bit configuration registers. The registers choose between an alignment mode and a calibration mode, and they hold four trim bytes: gain and offset for the sine channel and for the cosine channel. The block presents each setting as a parallel output. A store-command bit makes a single-cycle request pulse, which an external controller uses to copy the settings into non-volatile memory.

Any register can be read at any time. A write changes a setting only after a fixed key byte has been written to the key register. Every reset clears the key state, so the unlock must be repeated after each power-up. The serial lines are oversampled in the system clock domain. Because there is no select line, a frame starts again at bit zero whenever the serial clock has been quiet for a parameterised number of system cycles.

Top module: `cfg_spi_regbank`

## Requirements
- R1: While and after reset, all configuration outputs and `store_req` are 0, and the key state is locked.
- R2: A frame is 16 serial bits sampled on rising serial-clock edges, most significant bit first. Bit 15 is the direction (1 = write, 0 = read), bits 14:8 are the register address and bits 7:0 are the data. A read frame never changes a register.
- R3: In a read frame, the addressed register value is shifted out on the data-out line most significant bit first. Each bit is changed on a falling serial-clock edge, starting at the falling edge after the 8th rising edge. An address that maps to no register reads 0x00.
- R4: A write of 0xEB to address 0x1B unlocks the bank. A write of any other value to 0x1B locks it. Reading 0x1B returns 0x01 when unlocked and 0x00 when locked.
- R5: While the bank is locked, a write to any address other than 0x1B leaves every configuration output and register value unchanged.
- R6: While unlocked, writes reach the registers. Address 0x00 is the mode register (bit 0 alignment, bit 1 calibration, bit 7 store command). Addresses 0x01, 0x02, 0x03 and 0x04 hold sine gain, sine offset, cosine gain and cosine offset. Each written value appears on its output port and reads back.
- R7: Alignment mode and calibration mode are never both active. A mode write with bits 1 and 0 both set gives calibration mode only.
- R8: A mode-register write with bit 7 set makes `store_req` high for exactly one system cycle, and only while the bank is unlocked. Bit 7 always reads back as 0.
- R9: If the serial clock shows no edge for IDLE_LIMIT system cycles, a partly received frame is discarded and the next rising edge is taken as bit 15 of a new frame.
- R10: Reads return register contents whether the bank is locked or unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_clk | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| align_mode | output | 1 | Alignment mode active |
| cal_mode | output | 1 | Calibration mode active |
| sin_gain | output | 8 | Sine gain trim |
| sin_offset | output | 8 | Sine offset trim |
| cos_gain | output | 8 | Cosine gain trim |
| cos_offset | output | 8 | Cosine offset trim |
| store_req | output | 1 | One-cycle request to store the settings |

## Verification
The hardest situation to create from the ports is a frame abandoned partway, because no select line exists to mark a frame boundary. The bench clocks in five stray bits and then keeps the serial clock quiet for longer than the idle limit. After that it sends a key write followed by a key read, and it shows recovery by reading back the unlocked state. A misaligned frame would have left the bank locked. The bench also tries all 256 key values and checks that only 0xEB unlocks the bank. It checks that writes made while locked reach neither the outputs nor the store request.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
   localparam int CFG_DW         = 8;
   localparam int REG_MODE       = 0;
   localparam int REG_SIN_GAIN   = 1;
   localparam int REG_SIN_OFS    = 2;
   localparam int REG_COS_GAIN   = 3;
   localparam int REG_COS_OFS    = 4;
   localparam int MODE_ALIGN_BIT = 0;
   localparam int MODE_CAL_BIT   = 1;
   localparam int MODE_STORE_BIT = 7;

   typedef struct packed {
      logic              align;
      logic              cal;
      logic [CFG_DW-1:0] sin_gain;
      logic [CFG_DW-1:0] sin_ofs;
      logic [CFG_DW-1:0] cos_gain;
      logic [CFG_DW-1:0] cos_ofs;
   } cfg_t;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= '0;
            else        pipe <= d;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[STAGES-2:0], d};
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame #(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 8,
   parameter int IDLE_LIMIT = 64,
   localparam int FRAME_W   = 1 + ADDR_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_s,
   input  logic               sdi_s,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               hdr_stb,
   output logic [ADDR_W:0]    hdr_word,
   output logic               frame_stb,
   output logic [FRAME_W-1:0] rx_word,
   output logic               sdo
);
   localparam int CNT_W    = $clog2(FRAME_W);
   localparam int IDLE_W   = $clog2(IDLE_LIMIT + 1);
   localparam int HDR_LAST = ADDR_W;

   logic               sclk_d;
   logic               rise, fall;
   logic [CNT_W-1:0]   bit_cnt;
   logic [IDLE_W-1:0]  idle_cnt;
   logic [FRAME_W-1:0] sh;
   logic [DATA_W-1:0]  tx_sh;

   assign rise = sclk_s & ~sclk_d;
   assign fall = ~sclk_s & sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         bit_cnt   <= '0;
         idle_cnt  <= '0;
         sh        <= '0;
         tx_sh     <= '0;
         sdo       <= 1'b0;
         hdr_stb   <= 1'b0;
         frame_stb <= 1'b0;
      end else begin
         sclk_d    <= sclk_s;
         hdr_stb   <= 1'b0;
         frame_stb <= 1'b0;

         if (rise || fall)
            idle_cnt <= '0;
         else if (idle_cnt != IDLE_W'(IDLE_LIMIT))
            idle_cnt <= idle_cnt + 1'b1;

         if (rise) begin
            sh <= {sh[FRAME_W-2:0], sdi_s};
            if (bit_cnt == CNT_W'(HDR_LAST))
               hdr_stb <= 1'b1;
            if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
               frame_stb <= 1'b1;
               bit_cnt   <= '0;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end else if (!fall && idle_cnt == IDLE_W'(IDLE_LIMIT - 1)) begin
            bit_cnt <= '0;
         end

         if (hdr_stb)
            tx_sh <= hdr_word[ADDR_W] ? '0 : rd_data;
         else if (fall) begin
            sdo   <= tx_sh[DATA_W-1];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
         end else if (idle_cnt == IDLE_W'(IDLE_LIMIT - 1)) begin
            tx_sh <= '0;
            sdo   <= 1'b0;
         end
      end
   end

   assign hdr_word = sh[ADDR_W:0];
   assign rx_word  = sh;
endmodule

// File: rtl/cfg_spi_regs.sv
module cfg_spi_regs
   import cfg_spi_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int DATA_W  = 8,
   parameter int KEY_ADR = 'h1B,
   parameter int KEY_VAL = 'hEB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output cfg_t              cfg,
   output logic              unlocked,
   output logic              store_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg       <= '0;
         unlocked  <= 1'b0;
         store_req <= 1'b0;
      end else begin
         store_req <= 1'b0;
         if (wr_stb) begin
            if (wr_addr == ADDR_W'(KEY_ADR)) begin
               unlocked <= (wr_data == DATA_W'(KEY_VAL));
            end else if (unlocked) begin
               if (wr_addr == ADDR_W'(REG_MODE)) begin
                  cfg.cal   <= wr_data[MODE_CAL_BIT];
                  cfg.align <= wr_data[MODE_ALIGN_BIT] & ~wr_data[MODE_CAL_BIT];
                  store_req <= wr_data[MODE_STORE_BIT];
               end else if (wr_addr == ADDR_W'(REG_SIN_GAIN))
                  cfg.sin_gain <= wr_data;
               else if (wr_addr == ADDR_W'(REG_SIN_OFS))
                  cfg.sin_ofs <= wr_data;
               else if (wr_addr == ADDR_W'(REG_COS_GAIN))
                  cfg.cos_gain <= wr_data;
               else if (wr_addr == ADDR_W'(REG_COS_OFS))
                  cfg.cos_ofs <= wr_data;
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_MODE)) begin
         rd_data[MODE_ALIGN_BIT] = cfg.align;
         rd_data[MODE_CAL_BIT]   = cfg.cal;
      end else if (rd_addr == ADDR_W'(REG_SIN_GAIN)) rd_data = cfg.sin_gain;
      else if (rd_addr == ADDR_W'(REG_SIN_OFS))      rd_data = cfg.sin_ofs;
      else if (rd_addr == ADDR_W'(REG_COS_GAIN))     rd_data = cfg.cos_gain;
      else if (rd_addr == ADDR_W'(REG_COS_OFS))      rd_data = cfg.cos_ofs;
      else if (rd_addr == ADDR_W'(KEY_ADR))          rd_data[0] = unlocked;
   end
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank
   import cfg_spi_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int KEY_ADR     = 'h1B,
   parameter int KEY_VAL     = 'hEB,
   parameter int IDLE_LIMIT  = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_clk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              align_mode,
   output logic              cal_mode,
   output logic [DATA_W-1:0] sin_gain,
   output logic [DATA_W-1:0] sin_offset,
   output logic [DATA_W-1:0] cos_gain,
   output logic [DATA_W-1:0] cos_offset,
   output logic              store_req
);
   localparam int FRAME_W = 1 + ADDR_W + DATA_W;

   generate
      if (DATA_W != CFG_DW) begin : g_bad_dw
         $error("DATA_W must equal the package register width");
      end
      if (KEY_ADR >= (1 << ADDR_W)) begin : g_bad_key
         $error("KEY_ADR does not fit in ADDR_W bits");
      end
      if (IDLE_LIMIT < 4) begin : g_bad_idle
         $error("IDLE_LIMIT must be at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic               sclk_s, sdi_s;
   logic               hdr_stb, frame_stb, unlocked;
   logic [ADDR_W:0]    hdr_word;
   logic [FRAME_W-1:0] rx_word;
   logic [DATA_W-1:0]  rd_data;
   cfg_t               cfg;

   cfg_spi_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(spi_clk), .q(sclk_s));
   cfg_spi_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(sdi_s));

   cfg_spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_LIMIT(IDLE_LIMIT)) u_frame (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdi_s(sdi_s),
      .rd_data(rd_data), .hdr_stb(hdr_stb), .hdr_word(hdr_word),
      .frame_stb(frame_stb), .rx_word(rx_word), .sdo(spi_miso));

   cfg_spi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                  .KEY_ADR(KEY_ADR), .KEY_VAL(KEY_VAL)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(frame_stb & rx_word[FRAME_W-1]),
      .wr_addr(rx_word[FRAME_W-2:DATA_W]),
      .wr_data(rx_word[DATA_W-1:0]),
      .rd_addr(hdr_word[ADDR_W-1:0]),
      .rd_data(rd_data), .cfg(cfg),
      .unlocked(unlocked), .store_req(store_req));

   assign align_mode = cfg.align;
   assign cal_mode   = cfg.cal;
   assign sin_gain   = cfg.sin_gain;
   assign sin_offset = cfg.sin_ofs;
   assign cos_gain   = cfg.cos_gain;
   assign cos_offset = cfg.cos_ofs;
endmodule

// File: rtl/cfg_spi_regbank_chk.sv
module cfg_spi_regbank_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        frame_stb,
   input logic        unlocked,
   input logic        store_req,
   input logic        align_mode,
   input logic        cal_mode,
   input logic [31:0] trims
);
   logic [33:0] cfg_bits;
   assign cfg_bits = {align_mode, cal_mode, trims};

   assert_reset_locked_R1: assert property (@(posedge clk)
      !rst_n |=> (!unlocked && !store_req && cfg_bits == '0));

   assert_unlock_by_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> $past(frame_stb));

   assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(cfg_bits));

   assert_mode_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(align_mode && cal_mode));

   assert_store_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |=> !store_req);

   assert_store_when_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> unlocked);
endmodule

bind cfg_spi_regbank cfg_spi_regbank_chk u_chk (
   .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .unlocked(unlocked),
   .store_req(store_req), .align_mode(align_mode), .cal_mode(cal_mode),
   .trims({sin_gain, sin_offset, cos_gain, cos_offset}));

// File: tb/test_cfg_spi_regbank.sv
`timescale 1ns/1ps
module test_cfg_spi_regbank;
   localparam int HALF = 6;
   localparam int IDLE = 64;

   logic clk = 1'b0, rst_n = 1'b0, spi_clk = 1'b0, spi_mosi = 1'b0;
   logic spi_miso, align_mode, cal_mode, store_req;
   logic [7:0] sin_gain, sin_offset, cos_gain, cos_offset;

   int n_chk = 0, n_fail = 0, st_cycles = 0, st_pulses = 0;
   logic st_prev = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cfg_spi_regbank #(.IDLE_LIMIT(IDLE)) i_cfg_spi_regbank (
      .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .align_mode(align_mode), .cal_mode(cal_mode),
      .sin_gain(sin_gain), .sin_offset(sin_offset), .cos_gain(cos_gain),
      .cos_offset(cos_offset), .store_req(store_req));

   always @(posedge clk) begin
      if (store_req) st_cycles <= st_cycles + 1;
      if (store_req && !st_prev) st_pulses <= st_pulses + 1;
      st_prev <= store_req;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [6:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
      logic [15:0] w;
      w  = {wr, a, d};
      rd = '0;
      for (int i = 15; i >= 0; i--) begin
         spi_mosi = w[i];
         tick(HALF);
         if (i < 8) rd[i] = spi_miso;
         spi_clk = 1'b1;
         tick(HALF);
         spi_clk = 1'b0;
      end
      tick(HALF);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      xfer(1'b1, a, d, dummy);
   endtask

   task automatic rd(input logic [6:0] a, output logic [7:0] v);
      xfer(1'b0, a, 8'hFF, v);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog run did not complete");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int p0, c0;
      tick(5);
      chk("R1", "sin_gain in reset", int'(sin_gain), 0);
      rst_n = 1'b1;
      tick(5);
      chk("R1", "all outputs after reset",
          int'({align_mode, cal_mode, sin_gain, sin_offset, cos_gain, cos_offset, store_req}), 0);
      rd(7'h1B, v);
      chk("R1", "key read after reset", int'(v), 0);

      // locked writes are ignored, reads allowed
      wr(7'h01, 8'h5A);
      chk("R5", "sin_gain after locked write", int'(sin_gain), 0);
      rd(7'h01, v);
      chk("R10", "read while locked", int'(v), 0);
      p0 = st_pulses;
      wr(7'h00, 8'h83);
      tick(4);
      chk("R8", "no store pulse while locked", st_pulses, p0);
      chk("R5", "modes after locked write", int'({align_mode, cal_mode}), 0);

      // sweep every key value
      for (int k = 0; k < 256; k++) begin
         wr(7'h1B, 8'(k));
         rd(7'h1B, v);
         chk("R4", $sformatf("key state after value %0h", k), int'(v), (k == 'hEB) ? 1 : 0);
      end

      wr(7'h1B, 8'hEB);
      for (int r = 1; r <= 4; r++) begin
         for (int k = 0; k < 8; k++) begin
            logic [7:0] val;
            int port;
            val = 8'((k * 37 + r * 11 + 5) & 255);
            wr(7'(r), val);
            case (r)
               1: port = int'(sin_gain);
               2: port = int'(sin_offset);
               3: port = int'(cos_gain);
               default: port = int'(cos_offset);
            endcase
            chk("R6", $sformatf("port of reg %0d", r), port, int'(val));
            rd(7'(r), v);
            chk("R2", $sformatf("readback of reg %0d", r), int'(v), int'(val));
         end
      end
      chk("R6", "final trims",
          int'({sin_gain, sin_offset, cos_gain, cos_offset}),
          int'({8'(7*37+11+5), 8'(7*37+22+5), 8'(7*37+33+5), 8'(7*37+44+5)}));

      // mode priority
      wr(7'h00, 8'h03);
      chk("R7", "both set gives cal only", int'({align_mode, cal_mode}), 1);
      rd(7'h00, v);
      chk("R7", "mode readback both set", int'(v), 2);
      wr(7'h00, 8'h01);
      chk("R6", "align only", int'({align_mode, cal_mode}), 2);
      wr(7'h00, 8'h02);
      chk("R6", "cal only", int'({align_mode, cal_mode}), 1);

      // store pulse
      p0 = st_pulses; c0 = st_cycles;
      wr(7'h00, 8'h81);
      tick(4);
      chk("R8", "store pulse count", st_pulses - p0, 1);
      chk("R8", "store pulse width", st_cycles - c0, 1);
      rd(7'h00, v);
      chk("R8", "store bit reads zero", int'(v), 1);

      // read frame with data bits set writes nothing
      rd(7'h02, v);
      chk("R2", "read frame leaves reg", int'(sin_offset), int'(8'(7*37+22+5)));

      // unmapped addresses
      rd(7'h10, v);
      chk("R3", "unmapped 0x10", int'(v), 0);
      rd(7'h7F, v);
      chk("R3", "unmapped 0x7F", int'(v), 0);
      rd(7'h03, v);
      chk("R3", "shift-out of reg 3", int'(v), int'(8'(7*37+33+5)));

      // relock with a wrong key
      wr(7'h1B, 8'h00);
      rd(7'h1B, v);
      chk("R4", "relocked by wrong key", int'(v), 0);
      wr(7'h01, 8'hC3);
      chk("R5", "sin_gain held while relocked", int'(sin_gain), int'(8'(7*37+11+5)));
      p0 = st_pulses;
      wr(7'h00, 8'h82);
      tick(4);
      chk("R8", "no store after relock", st_pulses, p0);
      chk("R5", "mode held while relocked", int'({align_mode, cal_mode}), 2);
      rd(7'h01, v);
      chk("R10", "read after relock", int'(v), int'(8'(7*37+11+5)));

      // abandoned partial frame, then idle resync
      for (int i = 0; i < 5; i++) begin
         spi_mosi = 1'b1;
         tick(HALF);
         spi_clk = 1'b1;
         tick(HALF);
         spi_clk = 1'b0;
      end
      spi_mosi = 1'b0;
      tick(IDLE + 20);
      wr(7'h1B, 8'hEB);
      rd(7'h1B, v);
      chk("R9", "unlock after resync", int'(v), 1);

      // reset clears everything, including the key
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(3);
      chk("R1", "outputs after second reset",
          int'({align_mode, cal_mode, sin_gain, sin_offset, cos_gain, cos_offset}), 0);
      rd(7'h1B, v);
      chk("R1", "locked after second reset", int'(v), 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule